// File: doc/BRIEF.md
# Direct-Mapped Instruction Cache with Control Register

This block is a small read-only instruction cache between an instruction-fetch port and a memory bus. It holds 256 bytes of instructions as 64 entries of one 32-bit word each. Every entry has a valid bit and a 24-bit tag. A fetch that hits is answered in the cycle it is presented. A fetch that misses is sent to memory over a request/acknowledge handshake. The fetch port stalls until the memory word returns, and in the acknowledge cycle that word is handed to the requester and, when allowed, written into the entry.

Software controls the cache through a supervisor register port with two registers, selected by one bit: a control register and an entry-address register. In the control register, bit 0 turns lookups on, bit 1 freezes the contents, and two trigger bits invalidate either one indexed entry or all entries. Freezing is meant to keep a hot loop resident while it calls code that would otherwise evict it.

Top module: `icache_top`

## Requirements
- R1: Geometry: fetch address bits 7:2 select one of 64 entries and bits 31:8 form the tag. Two addresses that share bits 7:2 but differ in bits 31:8 evict each other.
- R2: While control bit 0 (enable) is 0, every fetch goes to memory and never completes from the cache. Such fetches allocate nothing. Enable changes only on a control register write.
- R3: Synchronous reset (active high) clears enable and freeze, sets the address register to 0, and invalidates all entries. Both registers read as zero after reset.
- R4: While control bit 1 (freeze) is 1, hits are still served from the cache, but a miss writes nothing into the cache.
- R5: Writing the control register with bit 2 set invalidates the entry whose index is held in bits 7:2 of the address register. Other entries are unaffected. The effect is visible from the next cycle.
- R6: Writing the control register with bit 3 set invalidates all 64 entries from the next cycle on.
- R7: A control register read returns enable in bit 0 and freeze in bit 1, with all other bits zero. Trigger bits 2 and 3 always read as 0. The address register reads back the full 32-bit value written. Register select 0 addresses the control register and 1 addresses the address register.
- R8: With enable set, a hit raises fetch_ready in the same cycle as fetch_req, with the cached word and no memory request. A miss returns the memory word in the acknowledge cycle. When not frozen, the miss fills the entry so that the next fetch of that address hits.
- R9: If an invalidation and a miss fill hit the same entry on the same clock edge, the invalidation wins and the entry is left invalid.
- R10: A miss raises mem_req the cycle after the lookup. mem_req and mem_addr then hold steady, and fetch_ready stays low, until mem_ack.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_req | input | 1 | Fetch request, held until fetch_ready |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Fetch completes this cycle |
| fetch_data | output | 32 | Instruction word, valid with fetch_ready |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read address |
| mem_ack | input | 1 | Memory read data valid |
| mem_data | input | 32 | Memory read data |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 entry address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel |

## Verification
A wrong valid bit or tag shows up at the ports on the next fetch to that index. A stale entry answers without raising mem_req and returns the old word where a memory round trip was expected. A lost fill raises mem_req where a same-cycle hit was expected. The bench changes the memory contents between passes, so a word served from the wrong place differs from the expected value in the cycle that fetch_ready rises. Control state errors show on the very next register read or fetch.

// File: rtl/icache_pkg.sv
package icache_pkg;

    localparam int unsigned XLEN       = 32;
    localparam int unsigned LINE_IDX_W = 6;
    localparam int unsigned WORD_OFS_W = 2;

    // control register bit positions (software visible)
    localparam int unsigned CB_ENABLE   = 0;
    localparam int unsigned CB_FREEZE   = 1;
    localparam int unsigned CB_DROP_ONE = 2;
    localparam int unsigned CB_DROP_ALL = 3;

    typedef struct packed {
        logic freeze;
        logic enable;
    } ctl_t;

    typedef enum logic {
        REG_CTL  = 1'b0,
        REG_ADDR = 1'b1
    } reg_sel_e;

    typedef enum logic {
        FS_LOOKUP = 1'b0,
        FS_REFILL = 1'b1
    } fstate_e;

    function automatic logic [XLEN-1:0] ctl_view(ctl_t c);
        logic [XLEN-1:0] v;
        v            = '0;
        v[CB_ENABLE] = c.enable;
        v[CB_FREEZE] = c.freeze;
        return v;
    endfunction

endpackage

// File: rtl/icache_regs.sv
module icache_regs
    import icache_pkg::*;
#(
    parameter int unsigned REG_W  = XLEN,
    parameter int unsigned IDX_W  = LINE_IDX_W,
    parameter int unsigned OFS_W  = WORD_OFS_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output ctl_t             ctl,
    output logic             drop_one,
    output logic             drop_all,
    output logic [IDX_W-1:0] drop_idx
);

    ctl_t             ctl_q;
    logic [REG_W-1:0] addr_q;
    logic             ctl_wr;
    logic             addr_wr;

    assign ctl_wr  = wr && (reg_sel_e'(sel) == REG_CTL);
    assign addr_wr = wr && (reg_sel_e'(sel) == REG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            addr_q <= '0;
        end else begin
            if (ctl_wr) begin
                ctl_q.enable <= wdata[CB_ENABLE];
                ctl_q.freeze <= wdata[CB_FREEZE];
            end
            if (addr_wr) begin
                addr_q <= wdata;
            end
        end
    end

    // trigger bits act on the same edge as the write; never stored
    assign drop_one = ctl_wr && wdata[CB_DROP_ONE];
    assign drop_all = ctl_wr && wdata[CB_DROP_ALL];
    assign drop_idx = addr_q[IDX_W+OFS_W-1:OFS_W];

    assign ctl   = ctl_q;
    assign rdata = (reg_sel_e'(sel) == REG_ADDR) ? addr_q : ctl_view(ctl_q);

    AST_RESET_DISABLED: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl_q == '0) && (addr_q == '0)); // R3

    AST_CTL_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> $stable(ctl_q)); // R2

endmodule

// File: rtl/icache_store.sv
module icache_store
    import icache_pkg::*;
#(
    parameter int unsigned IDX_W  = LINE_IDX_W,
    parameter int unsigned TAG_W  = XLEN - LINE_IDX_W - WORD_OFS_W,
    parameter int unsigned DATA_W = XLEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              drop_one,
    input  logic [IDX_W-1:0]  drop_idx,
    input  logic              drop_all
);

    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [ENTRIES-1:0] valid_q;
    logic [TAG_W-1:0]   tag_mem  [ENTRIES];
    logic [DATA_W-1:0]  data_mem [ENTRIES];

    generate
        for (genvar e = 0; e < ENTRIES; e++) begin : g_valid
            logic hit_drop;
            logic hit_fill;
            assign hit_drop = drop_one && (drop_idx == IDX_W'(e));
            assign hit_fill = wr_en && (wr_idx == IDX_W'(e));
            // invalidation has priority over a fill on the same edge
            always_ff @(posedge clk) begin
                if (rst || drop_all || hit_drop) begin
                    valid_q[e] <= 1'b0;
                end else if (hit_fill) begin
                    valid_q[e] <= 1'b1;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx]  <= wr_tag;
            data_mem[wr_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_mem[rd_idx];
    assign rd_data  = data_mem[rd_idx];

    AST_DROP_ALL_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        drop_all |=> (valid_q == '0)); // R6

    AST_DROP_ONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        drop_one |=> !valid_q[$past(drop_idx)]); // R5

    AST_DROP_BEATS_FILL: assert property (@(posedge clk) disable iff (rst)
        (drop_one && wr_en && (drop_idx == wr_idx)) |=> !valid_q[$past(wr_idx)]); // R9

endmodule

// File: rtl/icache_fetch.sv
module icache_fetch
    import icache_pkg::*;
#(
    parameter int unsigned ADDR_W = XLEN,
    parameter int unsigned DATA_W = XLEN,
    parameter int unsigned IDX_W  = LINE_IDX_W,
    parameter int unsigned OFS_W  = WORD_OFS_W,
    parameter int unsigned TAG_W  = ADDR_W - IDX_W - OFS_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ctl_t              ctl,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    output logic [IDX_W-1:0]  rd_idx,
    input  logic              rd_valid,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [DATA_W-1:0] rd_data,
    output logic              fill_we,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [TAG_W-1:0]  fill_tag,
    output logic [DATA_W-1:0] fill_data
);

    fstate_e           state_q, state_d;
    logic [ADDR_W-1:0] miss_addr_q;
    logic              lookup_hit;
    logic [OFS_W-1:0]  unused_ofs;

    assign unused_ofs = fetch_addr[OFS_W-1:0];

    assign rd_idx     = fetch_addr[IDX_W+OFS_W-1:OFS_W];
    assign lookup_hit = ctl.enable && rd_valid
                        && (rd_tag == fetch_addr[ADDR_W-1:IDX_W+OFS_W]);

    always_comb begin
        state_d     = state_q;
        fetch_ready = 1'b0;
        fetch_data  = rd_data;
        mem_req     = 1'b0;
        fill_we     = 1'b0;
        unique case (state_q)
            FS_LOOKUP: begin
                if (fetch_req) begin
                    if (lookup_hit) begin
                        fetch_ready = 1'b1;
                    end else begin
                        state_d = FS_REFILL;
                    end
                end
            end
            FS_REFILL: begin
                mem_req    = 1'b1;
                fetch_data = mem_data;
                if (mem_ack) begin
                    fetch_ready = 1'b1;
                    fill_we     = ctl.enable && !ctl.freeze;
                    state_d     = FS_LOOKUP;
                end
            end
            default: state_d = FS_LOOKUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= FS_LOOKUP;
            miss_addr_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == FS_LOOKUP && state_d == FS_REFILL) begin
                miss_addr_q <= fetch_addr;
            end
        end
    end

    assign mem_addr  = miss_addr_q;
    assign fill_idx  = miss_addr_q[IDX_W+OFS_W-1:OFS_W];
    assign fill_tag  = miss_addr_q[ADDR_W-1:IDX_W+OFS_W];
    assign fill_data = mem_data;

    AST_FROZEN_NO_FILL: assert property (@(posedge clk) disable iff (rst)
        ctl.freeze |-> !fill_we); // R4

    AST_DISABLED_GOES_OUT: assert property (@(posedge clk) disable iff (rst)
        (fetch_ready && !ctl.enable) |-> (mem_req && mem_ack)); // R2

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R10

    AST_HIT_WITHOUT_BUS: assert property (@(posedge clk) disable iff (rst)
        (fetch_ready && !mem_req) |-> (ctl.enable && rd_valid)); // R8

endmodule

// File: rtl/icache_top.sv
module icache_top
    import icache_pkg::*;
#(
    parameter int unsigned ADDR_W = XLEN,
    parameter int unsigned DATA_W = XLEN,
    parameter int unsigned IDX_W  = LINE_IDX_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data,
    input  logic              reg_wr,
    input  logic              reg_sel,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata
);

    localparam int unsigned OFS_W = WORD_OFS_W;
    localparam int unsigned TAG_W = ADDR_W - IDX_W - OFS_W;

    ctl_t              ctl;
    logic              drop_one, drop_all;
    logic [IDX_W-1:0]  drop_idx;
    logic [IDX_W-1:0]  rd_idx;
    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [DATA_W-1:0] rd_data;
    logic              fill_we;
    logic [IDX_W-1:0]  fill_idx;
    logic [TAG_W-1:0]  fill_tag;
    logic [DATA_W-1:0] fill_data;

    icache_regs #(
        .REG_W (ADDR_W),
        .IDX_W (IDX_W),
        .OFS_W (OFS_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctl      (ctl),
        .drop_one (drop_one),
        .drop_all (drop_all),
        .drop_idx (drop_idx)
    );

    icache_store #(
        .IDX_W  (IDX_W),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (fill_we),
        .wr_idx   (fill_idx),
        .wr_tag   (fill_tag),
        .wr_data  (fill_data),
        .drop_one (drop_one),
        .drop_idx (drop_idx),
        .drop_all (drop_all)
    );

    icache_fetch #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .OFS_W  (OFS_W),
        .TAG_W  (TAG_W)
    ) u_fetch (
        .clk         (clk),
        .rst         (rst),
        .ctl         (ctl),
        .fetch_req   (fetch_req),
        .fetch_addr  (fetch_addr),
        .fetch_ready (fetch_ready),
        .fetch_data  (fetch_data),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_ack     (mem_ack),
        .mem_data    (mem_data),
        .rd_idx      (rd_idx),
        .rd_valid    (rd_valid),
        .rd_tag      (rd_tag),
        .rd_data     (rd_data),
        .fill_we     (fill_we),
        .fill_idx    (fill_idx),
        .fill_tag    (fill_tag),
        .fill_data   (fill_data)
    );

endmodule

// File: tb/tb_icache_top.sv
`timescale 1ns/1ps
module tb_icache_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready;
    logic [31:0] fetch_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    always #2.5 clk = ~clk;

    icache_top dut (
        .clk(clk), .rst(rst),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data),
        .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [31:0] gen = 32'h0;

    // bench-side expectation of the cache contents
    bit          m_en = 0, m_fz = 0;
    logic [31:0] m_caar = '0;
    bit          m_v   [64];
    logic [23:0] m_tag [64];
    logic [31:0] m_dat [64];

    function automatic logic [31:0] mval(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ gen;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary_and_end();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary_and_end();
        end
    end

    task automatic model_ctl(input logic [31:0] d);
        m_en = d[0];
        m_fz = d[1];
        if (d[3]) for (int e = 0; e < 64; e++) m_v[e] = 0;
        if (d[2]) m_v[m_caar[7:2]] = 0;
    endtask

    task automatic wr_reg(input bit sel, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (sel) m_caar = d; else model_ctl(d);
    endtask

    task automatic rd_chk(input bit sel, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_sel = sel;
        #1;
        chk(reg_rdata === exp, req, reg_rdata, exp);
    endtask

    task automatic do_fetch(input logic [31:0] a, input string req,
                            input bit ack_wr, input logic [31:0] ack_ctl);
        int          i;
        bit          eh, gh;
        logic [31:0] ed, gd;
        int          lat;
        i  = int'(a[7:2]);
        eh = m_en && m_v[i] && (m_tag[i] == a[31:8]);
        ed = eh ? m_dat[i] : mval(a);
        @(negedge clk);
        fetch_req = 1'b1; fetch_addr = a;
        #1;
        if (fetch_ready) begin
            gh = 1; gd = fetch_data;
        end else begin
            gh  = 0;
            lat = int'(a[5:2]) % 3;
            @(negedge clk); #1;
            for (int k = 0; k < lat; k++) begin
                // R10: request and address held, fetch stalled
                chk(mem_req && !fetch_ready && mem_addr == a, "R10", mem_addr, a);
                @(negedge clk); #1;
            end
            chk(mem_req === 1'b1 && mem_addr === a, "R10", mem_addr, a);
            mem_ack = 1'b1; mem_data = mval(a);
            if (ack_wr) begin
                reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = ack_ctl;
            end
            #1;
            chk(fetch_ready === 1'b1, "R8", {31'b0, fetch_ready}, 32'd1);
            gd = fetch_data;
        end
        chk(gh == eh, req, {31'b0, gh}, {31'b0, eh});
        chk(gd === ed, req, gd, ed);
        if (!eh && m_en && !m_fz) begin
            m_v[i] = 1; m_tag[i] = a[31:8]; m_dat[i] = mval(a);
        end
        if (ack_wr) model_ctl(ack_ctl);
        @(negedge clk);
        fetch_req = 1'b0; mem_ack = 1'b0; reg_wr = 1'b0;
    endtask

    localparam logic [31:0] BASE_A = 32'h0001_2000;
    localparam logic [31:0] BASE_B = 32'h00AB_CD00;
    localparam logic [31:0] BASE_C = 32'h7F00_0100;

    initial begin
        for (int e = 0; e < 64; e++) begin m_v[e] = 0; m_tag[e] = '0; m_dat[e] = '0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R3: reset state
        rd_chk(1'b0, 32'h0, "R3");
        rd_chk(1'b1, 32'h0, "R3");
        #1;
        chk(mem_req === 1'b0 && fetch_ready === 1'b0, "R3", {30'b0, mem_req, fetch_ready}, 32'h0);

        // R2: disabled cache goes to memory and allocates nothing
        gen = 32'h1111_0000;
        do_fetch(BASE_A, "R2", 0, 0);
        do_fetch(BASE_A, "R2", 0, 0);
        wr_reg(1'b0, 32'h1);
        do_fetch(BASE_A, "R2", 0, 0);   // miss: nothing was allocated while off
        do_fetch(BASE_A, "R8", 0, 0);   // now resident

        // R7: read-back rules
        wr_reg(1'b0, 32'hFFFF_FFFD);
        rd_chk(1'b0, 32'h0000_0001, "R7");
        wr_reg(1'b1, 32'hDEAD_BEEF);
        rd_chk(1'b1, 32'hDEAD_BEEF, "R7");
        wr_reg(1'b0, 32'h3);
        rd_chk(1'b0, 32'h0000_0003, "R7");
        wr_reg(1'b0, 32'h1);

        // R8 / R1: fill every entry, then hit every entry with changed memory
        gen = 32'h2222_0000;
        for (int k = 0; k < 64; k++) do_fetch(BASE_A + 32'(k * 4), "R8", 0, 0);
        gen = 32'h3333_0000;
        for (int k = 0; k < 64; k++) do_fetch(BASE_A + 32'(k * 4), "R8", 0, 0);

        // R1: tag conflicts evict
        for (int k = 0; k < 64; k++) do_fetch(BASE_B + 32'(k * 4), "R1", 0, 0);
        for (int k = 0; k < 64; k++) do_fetch(BASE_A + 32'(k * 4), "R1", 0, 0);

        // R5: single-entry invalidation for every index, neighbour unaffected
        gen = 32'h4444_0000;
        for (int k = 0; k < 64; k++) begin
            wr_reg(1'b1, 32'hABCD_0003 | 32'(k << 2));
            wr_reg(1'b0, 32'h5);
            do_fetch(BASE_A + 32'(k * 4), "R5", 0, 0);
            do_fetch(BASE_A + 32'((k ^ 1) * 4), "R5", 0, 0);
        end

        // R6: clear all
        wr_reg(1'b0, 32'h9);
        gen = 32'h5555_0000;
        for (int k = 0; k < 64; k++) do_fetch(BASE_A + 32'(k * 4), "R6", 0, 0);

        // R4: freeze keeps hits, blocks allocation
        wr_reg(1'b0, 32'h3);
        gen = 32'h6666_0000;
        for (int k = 0; k < 64; k += 3) begin
            do_fetch(BASE_C + 32'(k * 4), "R4", 0, 0);
            do_fetch(BASE_C + 32'(k * 4), "R4", 0, 0);
            do_fetch(BASE_A + 32'(k * 4), "R4", 0, 0);
        end
        wr_reg(1'b0, 32'h1);
        do_fetch(BASE_C, "R4", 0, 0);
        do_fetch(BASE_C, "R4", 0, 0);

        // R9: invalidation on the same edge as the fill wins
        for (int k = 8; k < 16; k++) begin
            wr_reg(1'b1, BASE_B + 32'(k * 4));
            do_fetch(BASE_B + 32'(k * 4), "R9", 1, 32'h5);
            do_fetch(BASE_B + 32'(k * 4), "R9", 0, 0);
        end
        do_fetch(BASE_C + 32'h40, "R9", 1, 32'h9);
        do_fetch(BASE_C + 32'h40, "R9", 0, 0);
        do_fetch(BASE_C + 32'h40, "R9", 0, 0);

        // R2: disabling bypasses resident entries; re-enabling finds them again
        wr_reg(1'b0, 32'h0);
        gen = 32'h7777_0000;
        do_fetch(BASE_C + 32'h40, "R2", 0, 0);
        wr_reg(1'b0, 32'h1);
        do_fetch(BASE_C + 32'h40, "R2", 0, 0);

        summary_and_end();
    end

endmodule